// File: doc/BRIEF.md
# Bus Reset Sequencer

This block sequences reset for one agent on a shared bus. An asynchronous active-low reset request and a management interrupt request are brought into the bus clock domain. A small state machine then decides when the agent's core is held in reset and when its bus drivers may be enabled. It also decides whether the agent must float all of its outputs. The power-good input acts as the block's master reset: while it is low, everything returns to a known value at once and nothing pending survives.

The width of every reset pulse is measured in bus clocks. A release that comes too early raises a short-pulse flag. A request held past the upper limit while power is good raises a sticky over-length flag. Both limits are parameters, so a simulation can use small values. The configuration strap inputs are captured on the cycle in which the release is acted on, and they are held until the next release.

The release can also find the management interrupt active. In that case the block does not start normal operation. It enters a lock state with all outputs floating, and only a fresh reset request leaves that state.

States: `ST_HOLD` (core in reset, drivers off, counting the width), `ST_RUN` (normal operation), `ST_TRI` (outputs floated). Transitions: `T_RELEASE` (from `ST_HOLD` to `ST_RUN`: request released, interrupt inactive), `T_LOCK` (from `ST_HOLD` to `ST_TRI`: request released, interrupt active), `T_ASSERT` (from `ST_RUN` or `ST_TRI` back to `ST_HOLD`: request seen low).

Top module: `bus_rst_seq`

## Requirements
- R1: While `pwr_good` is low, the block is forced asynchronously to `ST_HOLD`. In that state `core_rst`=1, `drv_oe`=0, `tri_all`=0, `strap_q`=0, `rst_short_err`=0 and `rst_long_err`=0.
- R2: After `rst_req_n` falls, `drv_oe` and `core_rst` keep their old values through the second rising edge. They change on the third: `drv_oe` goes to 0 and `core_rst` goes to 1. The two synchronizer stages account for two edges and the state update for one.
- R3: After `rst_req_n` rises with `mgmt_irq` low, `drv_oe` goes to 1 and `core_rst` to 0 on the third rising edge of `clk`, and not before.
- R4: `strap_q` takes the value of `strap_in` on the edge that acts on the release (`T_RELEASE` or `T_LOCK`). It holds that value through later changes of `strap_in` and through the next reset request, until the next release.
- R5: `rst_short_err` goes to 1 on a release that comes after fewer than `MIN_CYC` cycles in `ST_HOLD`. It is cleared on `T_ASSERT`. A release after at least `MIN_CYC` cycles leaves it at 0.
- R6: `rst_long_err` goes to 1 once the block has spent `MAX_CYC` cycles in `ST_HOLD` with `pwr_good` high. It stays at 1 through later releases and requests, and only `pwr_good` low clears it.
- R7: If `mgmt_irq` is high when the release is acted on, the block takes `T_LOCK`: `tri_all`=1, `drv_oe`=0 and `core_rst`=0. It stays there whatever `mgmt_irq` does until a reset request, which brings it back to `ST_HOLD` with the R2 latency.
- R8: `mgmt_irq` has no effect while the block is in `ST_RUN`. `drv_oe` stays 1 and `tri_all` stays 0.
- R9: `drv_oe` and `tri_all` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pwr_good | input | 1 | Power good; low resets the block asynchronously |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| mgmt_irq | input | 1 | Asynchronous management interrupt request, active high |
| strap_in | input | STRAP_W | Configuration strap inputs |
| core_rst | output | 1 | Internal reset for the agent core, active high |
| drv_oe | output | 1 | Bus driver output enable |
| tri_all | output | 1 | Float all outputs (lock state) |
| strap_q | output | STRAP_W | Captured configuration straps |
| rst_short_err | output | 1 | Last reset pulse was shorter than MIN_CYC |
| rst_long_err | output | 1 | A reset pulse exceeded MAX_CYC with power good |

## Verification
The release edge can do two things in one cycle: capture the straps and choose between normal operation and the lock state from the interrupt. Both decisions come from the same synchronized sample. The bench drives the interrupt high and new strap values together with the release, then judges on the third edge that the lock state holds and that the straps were taken. It also releases a pulse that is too short in the same way, so that the short flag and the strap capture fall on the same edge and both are compared at that edge.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRI  = 2'd2
    } seq_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg[0] <= RST_VAL;
        end else begin
            stg[0] <= d;
        end
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                stg[i] <= RST_VAL;
            end else begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned MIN_CYC = 8,
    parameter int unsigned MAX_CYC = 40
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic run,
    output logic min_met,
    output logic max_hit
);

    localparam int unsigned CW = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && (cnt != MAX_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign min_met = (cnt >= MIN_V);
    assign max_hit = (cnt == MAX_V);

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bus_rst_seq.sv
module bus_rst_seq
    import bus_rst_pkg::*;
#(
    parameter int unsigned STRAP_W = 4,
    parameter int unsigned MIN_CYC = 8,
    parameter int unsigned MAX_CYC = 40
) (
    input  logic               clk,
    input  logic               pwr_good,
    input  logic               rst_req_n,
    input  logic               mgmt_irq,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               core_rst,
    output logic               drv_oe,
    output logic               tri_all,
    output logic [STRAP_W-1:0] strap_q,
    output logic               rst_short_err,
    output logic               rst_long_err
);

    seq_state_e state, nxt;
    logic [1:0] sync_q;
    logic       req_s, irq_s;
    logic       in_hold, release_ev, assert_ev;
    logic       min_met, max_hit;

    rst_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b00)
    ) u_sync (
        .clk    (clk),
        .arst_n (pwr_good),
        .d      ({mgmt_irq, rst_req_n}),
        .q      (sync_q)
    );

    assign req_s = sync_q[0];
    assign irq_s = sync_q[1];

    assign in_hold    = (state == ST_HOLD);
    assign release_ev = in_hold && req_s;
    assign assert_ev  = !in_hold && !req_s;

    hold_timer #(
        .MIN_CYC (MIN_CYC),
        .MAX_CYC (MAX_CYC)
    ) u_timer (
        .clk     (clk),
        .arst_n  (pwr_good),
        .clr     (!in_hold),
        .run     (in_hold),
        .min_met (min_met),
        .max_hit (max_hit)
    );

    strap_latch #(
        .WIDTH (STRAP_W)
    ) u_strap (
        .clk    (clk),
        .arst_n (pwr_good),
        .cap    (release_ev),
        .d      (strap_in),
        .q      (strap_q)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: if (req_s) nxt = irq_s ? ST_TRI : ST_RUN;
            ST_RUN:  if (!req_s) nxt = ST_HOLD;
            ST_TRI:  if (!req_s) nxt = ST_HOLD;
            default: nxt = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state <= ST_HOLD;
        end else begin
            state <= nxt;
        end
    end

    // pulse-width flags
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            rst_short_err <= 1'b0;
            rst_long_err  <= 1'b0;
        end else begin
            if (release_ev) begin
                rst_short_err <= !min_met;
            end else if (assert_ev) begin
                rst_short_err <= 1'b0;
            end
            if (in_hold && max_hit) begin
                rst_long_err <= 1'b1;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        core_rst = 1'b1;
        drv_oe   = 1'b0;
        tri_all  = 1'b0;
        unique case (state)
            ST_HOLD: begin
                core_rst = 1'b1;
            end
            ST_RUN: begin
                core_rst = 1'b0;
                drv_oe   = 1'b1;
            end
            ST_TRI: begin
                core_rst = 1'b0;
                tri_all  = 1'b1;
            end
            default: begin
                core_rst = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bus_rst_seq_chk.sv
module bus_rst_seq_chk #(
    parameter int unsigned STRAP_W = 4
) (
    input logic               clk,
    input logic               pwr_good,
    input logic               rst_req_n,
    input logic               core_rst,
    input logic               drv_oe,
    input logic               tri_all,
    input logic [STRAP_W-1:0] strap_q,
    input logic               rst_short_err,
    input logic               rst_long_err
);

    // R2
    oe_drop_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (!rst_req_n && !$past(rst_req_n) && !$past(rst_req_n, 2)) |=> !drv_oe);

    // R4
    strap_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !$stable(strap_q) |-> $fell(core_rst));

    // R5
    short_flag_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(rst_short_err) |-> $fell(core_rst));

    // R6
    long_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $past(rst_long_err) |-> rst_long_err);

    // R7
    tri_exit_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($past(tri_all) && !tri_all) |-> core_rst);

    // R9
    oe_tri_excl_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !(drv_oe && tri_all));

endmodule

bind bus_rst_seq bus_rst_seq_chk #(.STRAP_W(STRAP_W)) u_chk (
    .clk           (clk),
    .pwr_good      (pwr_good),
    .rst_req_n     (rst_req_n),
    .core_rst      (core_rst),
    .drv_oe        (drv_oe),
    .tri_all       (tri_all),
    .strap_q       (strap_q),
    .rst_short_err (rst_short_err),
    .rst_long_err  (rst_long_err)
);

// File: tb/test_bus_rst_seq.sv
module test_bus_rst_seq;

    localparam int STRAP_W = 4;
    localparam int MIN_CYC = 8;
    localparam int MAX_CYC = 40;

    localparam int K_OE = 0, K_TRI = 1, K_RST = 2, K_STRAP = 3, K_SHORT = 4, K_LONG = 5;

    logic               clk = 1'b0;
    logic               pwr_good = 1'b0;
    logic               rst_req_n = 1'b0;
    logic               mgmt_irq = 1'b0;
    logic [STRAP_W-1:0] strap_in = '0;
    logic               core_rst, drv_oe, tri_all, rst_short_err, rst_long_err;
    logic [STRAP_W-1:0] strap_q;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    kind;
        int    val;
        string tag;
    } exp_t;

    exp_t sb[$];

    bus_rst_seq #(
        .STRAP_W (STRAP_W),
        .MIN_CYC (MIN_CYC),
        .MAX_CYC (MAX_CYC)
    ) i_bus_rst_seq (
        .clk           (clk),
        .pwr_good      (pwr_good),
        .rst_req_n     (rst_req_n),
        .mgmt_irq      (mgmt_irq),
        .strap_in      (strap_in),
        .core_rst      (core_rst),
        .drv_oe        (drv_oe),
        .tri_all       (tri_all),
        .strap_q       (strap_q),
        .rst_short_err (rst_short_err),
        .rst_long_err  (rst_long_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(int kind);
        case (kind)
            K_OE:    return int'(drv_oe);
            K_TRI:   return int'(tri_all);
            K_RST:   return int'(core_rst);
            K_STRAP: return int'(strap_q);
            K_SHORT: return int'(rst_short_err);
            default: return int'(rst_long_err);
        endcase
    endfunction

    // driver side: queue an expectation dly negedges from now
    task automatic expect_at(int dly, int kind, int val, string tag);
        exp_t e;
        e.at = cyc + dly;
        e.kind = kind;
        e.val = val;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop due items and compare at the falling edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                n_run++;
                if (observe(sb[i].kind) != sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d cyc=%0d",
                             sb[i].tag, sb[i].kind, observe(sb[i].kind), sb[i].val, cyc);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1: reset state while power is not good
        expect_at(1, K_RST, 1, "R1");
        expect_at(1, K_OE, 0, "R1");
        expect_at(1, K_TRI, 0, "R1");
        expect_at(1, K_STRAP, 0, "R1");
        expect_at(1, K_SHORT, 0, "R1");
        expect_at(1, K_LONG, 0, "R1");
        tick(2);
        pwr_good = 1'b1;
        strap_in = 4'hA;
        tick(20);

        // R3 + R4: normal release after a proper width
        rst_req_n = 1'b1;
        expect_at(2, K_OE, 0, "R3");
        expect_at(2, K_RST, 1, "R3");
        expect_at(3, K_OE, 1, "R3");
        expect_at(3, K_RST, 0, "R3");
        expect_at(3, K_STRAP, 10, "R4");
        expect_at(3, K_SHORT, 0, "R5");
        tick(5);
        strap_in = 4'h5;
        expect_at(3, K_STRAP, 10, "R4");
        tick(4);

        // R8: interrupt while running is ignored
        mgmt_irq = 1'b1;
        expect_at(5, K_OE, 1, "R8");
        expect_at(5, K_TRI, 0, "R8");
        tick(6);
        mgmt_irq = 1'b0;
        tick(3);

        // R2: request drops drivers on the third edge
        strap_in = 4'h3;
        rst_req_n = 1'b0;
        expect_at(2, K_OE, 1, "R2");
        expect_at(2, K_RST, 0, "R2");
        expect_at(3, K_OE, 0, "R2");
        expect_at(3, K_RST, 1, "R2");
        expect_at(3, K_STRAP, 10, "R4");
        tick(3);
        // R5: release after only a few cycles -> short flag with capture
        rst_req_n = 1'b1;
        expect_at(3, K_SHORT, 1, "R5");
        expect_at(3, K_STRAP, 3, "R4");
        expect_at(3, K_OE, 1, "R3");
        tick(6);

        // R6: over-length request, then R7 lock with straps in the same edge
        rst_req_n = 1'b0;
        expect_at(3, K_SHORT, 0, "R5");
        tick(4);
        expect_at(1, K_LONG, 0, "R6");
        tick(56);
        expect_at(1, K_LONG, 1, "R6");
        expect_at(1, K_RST, 1, "R6");
        tick(2);
        strap_in = 4'hC;
        mgmt_irq = 1'b1;
        rst_req_n = 1'b1;
        expect_at(3, K_TRI, 1, "R7");
        expect_at(3, K_OE, 0, "R7");
        expect_at(3, K_RST, 0, "R7");
        expect_at(3, K_STRAP, 12, "R4");
        expect_at(3, K_LONG, 1, "R6");
        tick(5);
        mgmt_irq = 1'b0;
        expect_at(6, K_TRI, 1, "R7");
        expect_at(6, K_OE, 0, "R7");
        tick(8);
        rst_req_n = 1'b0;
        expect_at(2, K_TRI, 1, "R7");
        expect_at(3, K_TRI, 0, "R7");
        expect_at(3, K_RST, 1, "R7");
        tick(15);
        rst_req_n = 1'b1;
        expect_at(3, K_OE, 1, "R3");
        expect_at(3, K_TRI, 0, "R7");
        expect_at(3, K_SHORT, 0, "R5");
        expect_at(3, K_LONG, 1, "R6");
        tick(6);

        // R1 + R6: power loss clears everything asynchronously
        pwr_good = 1'b0;
        expect_at(1, K_LONG, 0, "R6");
        expect_at(1, K_RST, 1, "R1");
        expect_at(1, K_OE, 0, "R1");
        expect_at(1, K_STRAP, 0, "R1");
        tick(4);

        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule